// File: doc/BRIEF.md
# Pulse Chopper and Carrier Comparator

This block processes one signed audio sample per strobe. A phase accumulator inside the block produces a pulse and a carrier, and these drive one of three processing modes. In sign-flip mode the sample is multiplied by a pulse of -1/+1. In gate-chop mode the sample is multiplied by a pulse of 0/1. In compare mode the block outputs a comparator level, which is high while a second signed input is at or above the carrier. The pulse width comes from a base duty value plus an offset that scales with a control voltage. The duty is clamped after the offset is added.

Two level inputs work as triggers, reset and sync. Each input is turned into an edge when it crosses above half a volt. A sync edge always restarts the pulse phase. A reset edge restarts the pulse phase only when the target select names the pulse domain. A restart also clears the comparator memory that is used to soften compare-mode transitions. Every output is registered and carries a valid flag.

Top module: `pulse_chop_engine`

## Requirements
- R1: On each clock with `valid_i` high, the pulse phase used for that sample advances by `inc_i` modulo 2^24 for the next sample. The outputs update on the following clock, and `valid_o` is high for exactly that cycle. Without `valid_i`, the outputs hold their values.
- R2: The effective duty is an unsigned Q0.16 value, clamp(`duty_i` + offset, 655, 64881). The pulse is high while the sample's phase is less than the effective duty shifted left by 8.
- R3: The offset is clamp(`duty_cv_i`, -20480, 20480) × 8 / 5, truncated toward zero. In this scale 4096 LSB of the control input equals 1 V, so the offset adds at most ±0.5 of full duty.
- R4: With `mode_i`=0 or 3 (sign-flip), the output equals the input sample while the pulse is high. While the pulse is low, the output is the negated input, with -32768 mapping to 32767.
- R5: With `mode_i`=1 (gate chop), the output equals the input sample while the pulse is high and is 0 while it is low.
- R6: With `mode_i`=2 (compare), the comparator state is high when `cmp_src_i` >= carrier (signed). The high level is 32767. The low level is -32767 when `polarity_i`=1 and 0 when `polarity_i`=0. The output is the arithmetic average, shifted right by 1, of the current level and the level stored from the previous sample.
- R7: With `carrier_sel_i`=1, the carrier is the sawtooth: phase bits 23:8 with bit 15 inverted. With `carrier_sel_i`=0, it is the triangle: phase bits 22:7, bitwise inverted when phase bit 23 is set, and then bit 15 inverted.
- R8: `gate_o` is 32767 when the state is high. In gate-chop mode the state is the pulse; in compare mode it is the comparator. When the state is low, `gate_o` is 0 in gate-chop mode with `polarity_i`=0, and -32767 otherwise.
- R9: A trigger edge is seen on a valid sample whose level is above 2048 while the level on the previous valid sample was at or below 2048.
- R10: A sync edge restarts the pulse phase: that sample uses phase 0.
- R11: A reset edge restarts the pulse phase when `rst_target_i` is 0 (both) or 2 (pulse). It has no effect when the value is 1 (oscillator) or 3.
- R12: A restart clears the stored comparator level, so the restarted sample averages against the low level.
- R13: While `rst_ni` is low, all outputs are 0, `valid_o` is 0, the phase is 0, the stored trigger levels are 0 and the comparator memory is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Sample strobe |
| drive_i | input | 16 | Signed Q1.15 audio sample to chop |
| cmp_src_i | input | 16 | Signed Q1.15 compare-mode source |
| inc_i | input | 24 | Phase increment per sample |
| duty_i | input | 16 | Base duty, unsigned Q0.16 |
| duty_cv_i | input | 16 | Signed duty control, 4096 LSB per volt |
| mode_i | input | 2 | 0/3 sign-flip, 1 gate chop, 2 compare |
| carrier_sel_i | input | 1 | 0 triangle, 1 sawtooth |
| polarity_i | input | 1 | 0 unipolar, 1 bipolar |
| rst_target_i | input | 2 | 0 both, 1 oscillator, 2 pulse, 3 none |
| reset_lvl_i | input | 16 | Signed reset trigger level |
| sync_lvl_i | input | 16 | Signed sync trigger level |
| valid_o | output | 1 | Output valid |
| sample_o | output | 16 | Processed sample |
| gate_o | output | 16 | Gate state level |
| carrier_o | output | 16 | Active carrier sample |

## Verification
The assertions take for granted that the mode, polarity, audio and compare inputs are sampled on the same edge as `valid_i`. They check each registered output against those inputs one cycle earlier, and against the carrier that is registered with the same sample. The assertions also assume that the inputs carry no unknown values on a strobe edge. The stimulus changes inputs only on the falling clock edge, holds them through the strobe edge, and always drives every field with a defined value.

// File: rtl/pce_pkg.sv
package pce_pkg;
  typedef enum logic [1:0] {
    MODE_FLIP = 2'd0,
    MODE_CHOP = 2'd1,
    MODE_CMP  = 2'd2,
    MODE_RSV  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    TGT_BOTH  = 2'd0,
    TGT_OSC   = 2'd1,
    TGT_PULSE = 2'd2,
    TGT_NONE  = 2'd3
  } rst_tgt_e;
endpackage

// File: rtl/pce_edge_det.sv
module pce_edge_det #(
  parameter int LVL_W = 16,
  parameter int THRESH = 2048
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [LVL_W-1:0] lvl_i,
  output logic                    edge_o
);
  localparam logic signed [LVL_W-1:0] TH = LVL_W'(THRESH);

  logic signed [LVL_W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   prev_q <= '0;
    else if (en_i) prev_q <= lvl_i;
  end

  assign edge_o = en_i && (lvl_i > TH) && (prev_q <= TH);
endmodule

// File: rtl/pce_duty.sv
module pce_duty #(
  parameter int DUTY_W = 16,
  parameter int CV_W = 16,
  parameter int CV_ONE_V = 4096
) (
  input  logic [DUTY_W-1:0]      duty_i,
  input  logic signed [CV_W-1:0] cv_i,
  output logic [DUTY_W-1:0]      duty_o
);
  localparam int ACC_W = DUTY_W + CV_W + 2;
  localparam logic signed [ACC_W-1:0] CV_LIM  = ACC_W'(5 * CV_ONE_V);
  localparam logic signed [ACC_W-1:0] S_NUM   = ACC_W'(2 ** DUTY_W);
  localparam logic signed [ACC_W-1:0] S_DEN   = ACC_W'(10 * CV_ONE_V);
  localparam logic signed [ACC_W-1:0] D_MIN   = ACC_W'((2 ** DUTY_W) / 100);
  localparam logic signed [ACC_W-1:0] D_MAX   = ACC_W'(2 ** DUTY_W) - D_MIN;

  logic signed [ACC_W-1:0] cv_c, off, sum;

  always_comb begin
    cv_c = ACC_W'(cv_i);
    if (cv_c > CV_LIM)       cv_c = CV_LIM;
    else if (cv_c < -CV_LIM) cv_c = -CV_LIM;
    off = (cv_c * S_NUM) / S_DEN;
    sum = $signed({{(ACC_W-DUTY_W){1'b0}}, duty_i}) + off;
    if (sum < D_MIN)      sum = D_MIN;
    else if (sum > D_MAX) sum = D_MAX;
    duty_o = sum[DUTY_W-1:0];
  end
endmodule

// File: rtl/pce_phase.sv
module pce_phase #(
  parameter int PHASE_W = 24,
  parameter int DUTY_W = 16,
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic                       restart_i,
  input  logic [PHASE_W-1:0]         inc_i,
  input  logic [DUTY_W-1:0]          duty_i,
  input  logic                       saw_i,
  output logic                       pulse_o,
  output logic signed [SAMPLE_W-1:0] carrier_o
);
  localparam int SHIFT = PHASE_W - DUTY_W;

  logic [PHASE_W-1:0]  phase_q, p_use, thr;
  logic [SAMPLE_W-1:0] saw_u, fold_u, tri_u;

  assign p_use = restart_i ? '0 : phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   phase_q <= '0;
    else if (en_i) phase_q <= p_use + inc_i;
  end

  assign thr     = PHASE_W'(duty_i) << SHIFT;
  assign pulse_o = p_use < thr;

  // saw: top bits recentred; tri: fold on MSB then recentre
  assign saw_u  = p_use[PHASE_W-1 -: SAMPLE_W];
  assign fold_u = p_use[PHASE_W-2 -: SAMPLE_W];
  assign tri_u  = p_use[PHASE_W-1] ? ~fold_u : fold_u;

  always_comb begin
    if (saw_i) carrier_o = $signed({~saw_u[SAMPLE_W-1], saw_u[SAMPLE_W-2:0]});
    else       carrier_o = $signed({~tri_u[SAMPLE_W-1], tri_u[SAMPLE_W-2:0]});
  end
endmodule

// File: rtl/pulse_chop_engine.sv
module pulse_chop_engine #(
  parameter int SAMPLE_W = 16,
  parameter int PHASE_W = 24,
  parameter int DUTY_W = 16,
  parameter int CV_ONE_V = 4096
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic signed [SAMPLE_W-1:0] drive_i,
  input  logic signed [SAMPLE_W-1:0] cmp_src_i,
  input  logic [PHASE_W-1:0]         inc_i,
  input  logic [DUTY_W-1:0]          duty_i,
  input  logic signed [SAMPLE_W-1:0] duty_cv_i,
  input  logic [1:0]                 mode_i,
  input  logic                       carrier_sel_i,
  input  logic                       polarity_i,
  input  logic [1:0]                 rst_target_i,
  input  logic signed [SAMPLE_W-1:0] reset_lvl_i,
  input  logic signed [SAMPLE_W-1:0] sync_lvl_i,
  output logic                       valid_o,
  output logic signed [SAMPLE_W-1:0] sample_o,
  output logic signed [SAMPLE_W-1:0] gate_o,
  output logic signed [SAMPLE_W-1:0] carrier_o
);
  import pce_pkg::*;

  localparam logic signed [SAMPLE_W-1:0] FULL  = SAMPLE_W'((2 ** (SAMPLE_W-1)) - 1);
  localparam logic signed [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam int TRIG_TH = CV_ONE_V / 2;

  mode_e    mode;
  rst_tgt_e tgt;
  logic sync_edge, reset_edge, restart;
  logic [DUTY_W-1:0] duty_eff;
  logic pulse, cmp_now, cmp_prev, cmp_q, state;
  logic signed [SAMPLE_W-1:0] carrier, neg, lo_lvl, lvl_now, lvl_prev, out_d, gate_d;
  logic signed [SAMPLE_W:0]   lvl_sum;

  assign mode = mode_e'(mode_i);
  assign tgt  = rst_tgt_e'(rst_target_i);

  pce_edge_det #(.LVL_W(SAMPLE_W), .THRESH(TRIG_TH)) i_sync_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(valid_i), .lvl_i(sync_lvl_i), .edge_o(sync_edge)
  );

  pce_edge_det #(.LVL_W(SAMPLE_W), .THRESH(TRIG_TH)) i_reset_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(valid_i), .lvl_i(reset_lvl_i), .edge_o(reset_edge)
  );

  assign restart = sync_edge || (reset_edge && (tgt == TGT_BOTH || tgt == TGT_PULSE));

  pce_duty #(.DUTY_W(DUTY_W), .CV_W(SAMPLE_W), .CV_ONE_V(CV_ONE_V)) i_duty (
    .duty_i(duty_i), .cv_i(duty_cv_i), .duty_o(duty_eff)
  );

  pce_phase #(.PHASE_W(PHASE_W), .DUTY_W(DUTY_W), .SAMPLE_W(SAMPLE_W)) i_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(valid_i), .restart_i(restart),
    .inc_i(inc_i), .duty_i(duty_eff), .saw_i(carrier_sel_i),
    .pulse_o(pulse), .carrier_o(carrier)
  );

  // comparator memory, cleared on pulse restart
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cmp_q <= 1'b0;
    else if (valid_i) cmp_q <= cmp_now;
  end

  always_comb begin
    cmp_now  = cmp_src_i >= carrier;
    cmp_prev = restart ? 1'b0 : cmp_q;
    state    = (mode == MODE_CMP) ? cmp_now : pulse;
    neg      = (drive_i == MOST_NEG) ? FULL : -drive_i;
    lo_lvl   = polarity_i ? -FULL : '0;
    lvl_now  = cmp_now  ? FULL : lo_lvl;
    lvl_prev = cmp_prev ? FULL : lo_lvl;
    lvl_sum  = (SAMPLE_W+1)'(lvl_now) + (SAMPLE_W+1)'(lvl_prev);
    unique case (mode)
      MODE_CHOP: out_d = pulse ? drive_i : '0;
      MODE_CMP:  out_d = SAMPLE_W'(lvl_sum >>> 1);
      default:   out_d = pulse ? drive_i : neg;
    endcase
    if (state)                                gate_d = FULL;
    else if (mode == MODE_CHOP && !polarity_i) gate_d = '0;
    else                                      gate_d = -FULL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      sample_o  <= '0;
      gate_o    <= '0;
      carrier_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        sample_o  <= out_d;
        gate_o    <= gate_d;
        carrier_o <= carrier;
      end
    end
  end
endmodule

// File: rtl/pce_checker.sv
module pce_checker #(
  parameter int SAMPLE_W = 16
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       valid_i,
  input logic signed [SAMPLE_W-1:0] drive_i,
  input logic signed [SAMPLE_W-1:0] cmp_src_i,
  input logic [1:0]                 mode_i,
  input logic                       polarity_i,
  input logic                       valid_o,
  input logic signed [SAMPLE_W-1:0] sample_o,
  input logic signed [SAMPLE_W-1:0] gate_o,
  input logic signed [SAMPLE_W-1:0] carrier_o
);
  localparam logic signed [SAMPLE_W-1:0] FULL = SAMPLE_W'((2 ** (SAMPLE_W-1)) - 1);

  p_valid_out_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_valid_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(sample_o) && $stable(gate_o) && $stable(carrier_o)));

  p_flip_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(mode_i) == 2'd0 && gate_o == FULL) |-> sample_o == $past(drive_i));

  p_chop_mute_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(mode_i) == 2'd1 && gate_o != FULL) |-> sample_o == '0);

  p_cmp_state_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(mode_i) == 2'd2) |-> ((gate_o == FULL) == ($past(cmp_src_i) >= carrier_o)));

  p_gate_levels_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (gate_o == FULL || gate_o == -FULL || gate_o == '0));

  p_gate_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && gate_o == '0) |-> ($past(mode_i) == 2'd1 && !$past(polarity_i)));
endmodule

bind pulse_chop_engine pce_checker #(.SAMPLE_W(SAMPLE_W)) i_pce_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .drive_i(drive_i),
  .cmp_src_i(cmp_src_i), .mode_i(mode_i), .polarity_i(polarity_i),
  .valid_o(valid_o), .sample_o(sample_o), .gate_o(gate_o), .carrier_o(carrier_o)
);

// File: tb/test_pulse_chop_engine.sv
module test_pulse_chop_engine;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic signed [15:0] drive_i = '0, cmp_src_i = '0, duty_cv_i = '0;
  logic signed [15:0] reset_lvl_i = '0, sync_lvl_i = '0;
  logic [23:0] inc_i = '0;
  logic [15:0] duty_i = 16'h8000;
  logic [1:0]  mode_i = '0, rst_target_i = '0;
  logic carrier_sel_i = 1'b0, polarity_i = 1'b1;
  logic valid_o;
  logic signed [15:0] sample_o, gate_o, carrier_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  pulse_chop_engine i_pulse_chop_engine (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .drive_i(drive_i),
    .cmp_src_i(cmp_src_i), .inc_i(inc_i), .duty_i(duty_i), .duty_cv_i(duty_cv_i),
    .mode_i(mode_i), .carrier_sel_i(carrier_sel_i), .polarity_i(polarity_i),
    .rst_target_i(rst_target_i), .reset_lvl_i(reset_lvl_i), .sync_lvl_i(sync_lvl_i),
    .valid_o(valid_o), .sample_o(sample_o), .gate_o(gate_o), .carrier_o(carrier_o)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        saw;
    logic        bip;
    logic [23:0] inc;
    logic [15:0] duty;
    logic [15:0] cv;
    logic [15:0] drv;
    logic [15:0] src;
    logic [15:0] e_out;
    logic [15:0] e_gate;
    logic [15:0] e_car;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    // R4 R7: flip, pulse high, tri
    '{2'd0, 1'b0, 1'b1, 24'h100000, 16'h8000, 16'sd0, 16'sd1000, 16'sd0, 16'sd1000, 16'sd32767, -16'sd24576},
    // R4 R7: flip, pulse low, saw
    '{2'd0, 1'b1, 1'b1, 24'hC00000, 16'h8000, 16'sd0, 16'sd1000, 16'sd0, -16'sd1000, -16'sd32767, 16'sd16384},
    // R4: most negative input saturates
    '{2'd0, 1'b0, 1'b1, 24'hC00000, 16'h8000, 16'sd0, -16'sd32768, 16'sd0, 16'sd32767, -16'sd32767, -16'sd1},
    // R5 R8: chop unipolar low
    '{2'd1, 1'b1, 1'b0, 24'hC00000, 16'h8000, 16'sd0, 16'sd5000, 16'sd0, 16'sd0, 16'sd0, 16'sd16384},
    // R5 R8: chop unipolar high
    '{2'd1, 1'b1, 1'b0, 24'h100000, 16'h8000, 16'sd0, 16'sd5000, 16'sd0, 16'sd5000, 16'sd32767, -16'sd28672},
    // R5 R8: chop bipolar low
    '{2'd1, 1'b0, 1'b1, 24'hC00000, 16'h8000, 16'sd0, 16'sd7, 16'sd0, 16'sd0, -16'sd32767, -16'sd1},
    // R2 R3: cv +5V clamps high end, below threshold
    '{2'd0, 1'b1, 1'b1, 24'hF00000, 16'h8000, 16'sd20480, 16'sd123, 16'sd0, 16'sd123, 16'sd32767, 16'sd28672},
    // R2 R3: cv over range, above threshold
    '{2'd0, 1'b1, 1'b1, 24'hFE0000, 16'h8000, 16'sd30000, 16'sd123, 16'sd0, -16'sd123, -16'sd32767, 16'sd32256},
    // R2 R3: low duty clamp, just below
    '{2'd0, 1'b1, 1'b1, 24'h028E00, 16'h0000, -16'sd20480, 16'sd200, 16'sd0, 16'sd200, 16'sd32767, -16'sd32114},
    // R2: low duty clamp, at threshold
    '{2'd0, 1'b1, 1'b1, 24'h028F00, 16'h0000, -16'sd20480, 16'sd200, 16'sd0, -16'sd200, -16'sd32767, -16'sd32113},
    // R3: -1V truncation, below
    '{2'd0, 1'b1, 1'b1, 24'h666600, 16'h8000, -16'sd4096, 16'sd50, 16'sd0, 16'sd50, 16'sd32767, -16'sd6554},
    // R3: -1V truncation, at threshold
    '{2'd0, 1'b1, 1'b1, 24'h666700, 16'h8000, -16'sd4096, 16'sd50, 16'sd0, -16'sd50, -16'sd32767, -16'sd6553},
    // R6: compare high after high
    '{2'd2, 1'b0, 1'b1, 24'h100000, 16'h8000, 16'sd0, 16'sd0, 16'sd0, 16'sd32767, 16'sd32767, -16'sd24576},
    // R6: compare falling, bipolar
    '{2'd2, 1'b0, 1'b1, 24'h100000, 16'h8000, 16'sd0, 16'sd0, -16'sd30000, 16'sd0, -16'sd32767, -16'sd24576},
    // R6: compare falling, unipolar
    '{2'd2, 1'b1, 1'b0, 24'h100000, 16'h8000, 16'sd0, 16'sd0, -16'sd30000, 16'sd16383, -16'sd32767, -16'sd28672},
    // R6: compare equal is high
    '{2'd2, 1'b1, 1'b1, 24'hC00000, 16'h8000, 16'sd0, 16'sd0, 16'sd16384, 16'sd32767, 16'sd32767, 16'sd16384}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one strobed sample; outputs are sampled at the following falling edge
  task automatic step();
    valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic sync_to_zero(input logic [23:0] inc);
    inc_i = inc;
    sync_lvl_i = 16'sd0;
    step();
    sync_lvl_i = 16'sd4096;
    step();
    sync_lvl_i = 16'sd0;
  endtask

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R13: reset state
    chk("R13", "valid_o", int'(valid_o), 0);
    chk("R13", "sample_o", int'(sample_o), 0);
    chk("R13", "gate_o", int'(gate_o), 0);
    chk("R13", "carrier_o", int'(carrier_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    foreach (VECS[i]) begin
      mode_i = VECS[i].mode;
      carrier_sel_i = VECS[i].saw;
      polarity_i = VECS[i].bip;
      duty_i = VECS[i].duty;
      duty_cv_i = $signed(VECS[i].cv);
      drive_i = $signed(VECS[i].drv);
      cmp_src_i = $signed(VECS[i].src);
      sync_to_zero(VECS[i].inc);
      step();
      chk("R2-R8 vec", "sample_o", int'(sample_o), int'($signed(VECS[i].e_out)));
      chk("R8 vec", "gate_o", int'(gate_o), int'($signed(VECS[i].e_gate)));
      chk("R7 vec", "carrier_o", int'(carrier_o), int'($signed(VECS[i].e_car)));
    end

    // R1: accumulation, valid timing, hold, wrap (saw carrier)
    mode_i = 2'd0; carrier_sel_i = 1'b1; polarity_i = 1'b1; duty_i = 16'h8000;
    duty_cv_i = '0; drive_i = 16'sd10;
    inc_i = 24'h100000; step();
    sync_lvl_i = 16'sd4096; step(); sync_lvl_i = '0;
    chk("R10", "carrier_o", int'(carrier_o), -32768);
    chk("R1", "valid_o", int'(valid_o), 1);
    step(); chk("R1", "carrier_o", int'(carrier_o), -28672);
    step(); chk("R1", "carrier_o", int'(carrier_o), -24576);
    drive_i = 16'sd999; inc_i = 24'h777777;
    repeat (3) @(negedge clk_i);
    chk("R1", "valid_o idle", int'(valid_o), 0);
    chk("R1", "carrier_o hold", int'(carrier_o), -24576);
    chk("R1", "sample_o hold", int'(sample_o), 10);
    sync_to_zero(24'hC00000);
    step(); chk("R1", "carrier_o", int'(carrier_o), 16384);
    step(); chk("R1", "carrier_o wrap", int'(carrier_o), 0);

    // R9: threshold strictly above 2048, previous at or below
    sync_to_zero(24'h100000);
    step(); chk("R9", "carrier_o", int'(carrier_o), -28672);
    sync_lvl_i = 16'sd2048; step(); chk("R9", "carrier at 2048", int'(carrier_o), -24576);
    sync_lvl_i = 16'sd2049; step(); chk("R9", "carrier at 2049", int'(carrier_o), -32768);
    sync_lvl_i = 16'sd4096; step(); chk("R9", "carrier held high", int'(carrier_o), -28672);
    sync_lvl_i = 16'sd0; step(); chk("R9", "carrier", int'(carrier_o), -24576);

    // R11: reset target
    rst_target_i = 2'd1; reset_lvl_i = 16'sd4096; step();
    chk("R11", "osc target", int'(carrier_o), -20480);
    reset_lvl_i = '0; step(); chk("R11", "carrier", int'(carrier_o), -16384);
    rst_target_i = 2'd2; reset_lvl_i = 16'sd4096; step();
    chk("R11", "pulse target", int'(carrier_o), -32768);
    reset_lvl_i = '0; step(); chk("R11", "carrier", int'(carrier_o), -28672);
    rst_target_i = 2'd0; reset_lvl_i = 16'sd4096; step();
    chk("R11", "both target", int'(carrier_o), -32768);
    reset_lvl_i = '0;

    // R12: restart clears comparator memory (tri carrier, bipolar)
    mode_i = 2'd2; carrier_sel_i = 1'b0; polarity_i = 1'b1;
    cmp_src_i = 16'sd32767; step();
    chk("R6", "gate high", int'(gate_o), 32767);
    cmp_src_i = 16'sd0; sync_lvl_i = 16'sd4096; step(); sync_lvl_i = '0;
    chk("R12", "sample after restart", int'(sample_o), 0);
    chk("R12", "gate after restart", int'(gate_o), 32767);
    step(); chk("R6", "sample high", int'(sample_o), 32767);
    cmp_src_i = -16'sd30000; step();
    chk("R6", "sample falling", int'(sample_o), 0);
    chk("R7", "tri carrier", int'(carrier_o), -16384);
    step(); chk("R6", "sample low", int'(sample_o), -32767);

    // R13: reset mid-run
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R13", "sample_o", int'(sample_o), 0);
    chk("R13", "carrier_o", int'(carrier_o), 0);
    rst_ni = 1'b1;
    mode_i = 2'd0; carrier_sel_i = 1'b1; inc_i = 24'h100000;
    step(); chk("R13", "phase zero", int'(carrier_o), -32768);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule